// File: doc/BRIEF.md
# Branch Condition Evaluator with Held Decision

This block decides whether a conditional return, jump or call in a small 8-bit processor takes its branch. It reads a two-bit condition field from the opcode, the zero and carry flags, and an unconditional-branch request. It reports the decision to the instruction sequencer on one active-low line: low means take the branch, high means fall through.

The raw decision passes through a gated node. The node shows the decision only while two clock phase enables are both high. At all other times the node is precharged to the not-taken level. A hold stage follows the node. It is transparent while the gate is open and keeps the last decision once the gate closes. Because of this, a sequencer that samples on a later edge still sees the correct value, even when the gating phases drop before that edge. Flag generation, wider opcode decode and the sequencer itself are outside the block.

Top module: `branch_cond_eval`

## Requirements
- R1: With condition field (opcode bits [4:3]) equal to 00, the decision is taken (take_n low) exactly when zf is 0.
- R2: With condition field 01, the decision is taken exactly when zf is 1.
- R3: With condition field 10, the decision is taken exactly when cf is 0.
- R4: With condition field 11, the decision is taken exactly when cf is 1.
- R5: Opcode bits outside [4:3] have no effect on the decision.
- R6: While ph_pri and ph_sec are not both high, changes on opcode, zf, cf and force_take have no effect on take_n.
- R7: When the gate closes, take_n keeps the value it had during the last open cycle.
- R8: After synchronous reset, and before the first open gate, take_n is 1 (not taken).
- R9: While the gate is open, force_take high drives take_n low, whatever the condition field and flags.
- R10: The sequence A=0, increment (zf=0) then test Z, decrement (zf=1) then test NZ, set carry then test NC, complement carry then test C gives not-taken for all four tests.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| opcode | input | OPC_W | Current opcode; bits [4:3] select the condition |
| zf | input | 1 | Zero flag |
| cf | input | 1 | Carry flag |
| force_take | input | 1 | Unconditional branch request |
| ph_pri | input | 1 | Primary phase enable |
| ph_sec | input | 1 | Secondary phase enable |
| take_n | output | 1 | Branch decision toward the sequencer, low = taken |

## Verification
The bench builds the block with its default parameters: an 8-bit opcode and the condition field at bit 3. With these values every real conditional-return opcode (0xC0, 0xC8, 0xD0, 0xD8) can be applied directly, and the upper and lower opcode bits can be flipped to show that they do not matter. A small accumulator-and-flags model in the bench runs the increment, decrement, set-carry and complement-carry sequence. Separate tasks open only one phase, or change the flags while the gate is closed, to show that the held decision survives the dead time between phases.

// File: rtl/bcond_pkg.sv
package bcond_pkg;

  typedef enum logic [1:0] {
    CC_NZ = 2'b00,
    CC_Z  = 2'b01,
    CC_NC = 2'b10,
    CC_C  = 2'b11
  } cc_e;

  // Returns 1 when the condition holds (branch should be taken).
  function automatic logic cc_holds(input cc_e cc, input logic zf, input logic cf);
    logic r;
    unique case (cc)
      CC_NZ:   r = ~zf;
      CC_Z:    r = zf;
      CC_NC:   r = ~cf;
      default: r = cf;
    endcase
    return r;
  endfunction

  // Active-low form, as driven toward the sequencer.
  function automatic logic decision_n(input cc_e cc, input logic zf, input logic cf,
                                      input logic force_take);
    return ~(force_take | cc_holds(cc, zf, cf));
  endfunction

endpackage

// File: rtl/bcond_select.sv
module bcond_select
  import bcond_pkg::*;
#(
  parameter int OPC_W    = 8,
  parameter int COND_LSB = 3
) (
  input  logic [OPC_W-1:0] opcode,
  input  logic             zf,
  input  logic             cf,
  input  logic             force_take,
  output logic             raw_n
);
  localparam int COND_MSB = COND_LSB + 1;

  cc_e cc_field;

  generate
    if (COND_MSB < OPC_W) begin : g_field
      assign cc_field = cc_e'(opcode[COND_MSB:COND_LSB]);
    end else begin : g_short
      assign cc_field = CC_NZ;
    end
  endgenerate

  always_comb raw_n = decision_n(cc_field, zf, cf, force_take);

endmodule

// File: rtl/bcond_gate.sv
module bcond_gate (
  input  logic ph_pri,
  input  logic ph_sec,
  input  logic raw_n,
  output logic gate_open,
  output logic node_n
);
  // Precharged node: shows the decision only with both phases high.
  always_comb begin
    gate_open = ph_pri & ph_sec;
    node_n    = gate_open ? raw_n : 1'b1;
  end
endmodule

// File: rtl/bcond_hold.sv
module bcond_hold (
  input  logic clk,
  input  logic rst,
  input  logic gate_open,
  input  logic node_n,
  output logic held_n
);
  always_ff @(posedge clk) begin
    if (rst)            held_n <= 1'b1;
    else if (gate_open) held_n <= node_n;
  end
endmodule

// File: rtl/branch_cond_eval.sv
module branch_cond_eval #(
  parameter int OPC_W    = 8,
  parameter int COND_LSB = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [OPC_W-1:0] opcode,
  input  logic             zf,
  input  logic             cf,
  input  logic             force_take,
  input  logic             ph_pri,
  input  logic             ph_sec,
  output logic             take_n
);
  logic raw_n;
  logic gate_open;
  logic node_n;
  logic held_n;

  bcond_select #(.OPC_W(OPC_W), .COND_LSB(COND_LSB)) u_sel (
    .opcode(opcode), .zf(zf), .cf(cf), .force_take(force_take), .raw_n(raw_n)
  );

  bcond_gate u_gate (
    .ph_pri(ph_pri), .ph_sec(ph_sec), .raw_n(raw_n),
    .gate_open(gate_open), .node_n(node_n)
  );

  bcond_hold u_hold (
    .clk(clk), .rst(rst), .gate_open(gate_open), .node_n(node_n), .held_n(held_n)
  );

  // Transparent while open, holding while closed.
  assign take_n = gate_open ? node_n : held_n;

  localparam int CM = COND_LSB + 1;

  // R1..R4: decision follows the selected flag while open
  a_r1_nz: assert property (@(posedge clk) disable iff (rst)
    (ph_pri && ph_sec && !force_take && opcode[CM:COND_LSB] == 2'b00) |-> (take_n == zf));
  a_r2_z: assert property (@(posedge clk) disable iff (rst)
    (ph_pri && ph_sec && !force_take && opcode[CM:COND_LSB] == 2'b01) |-> (take_n == !zf));
  a_r3_nc: assert property (@(posedge clk) disable iff (rst)
    (ph_pri && ph_sec && !force_take && opcode[CM:COND_LSB] == 2'b10) |-> (take_n == cf));
  a_r4_c: assert property (@(posedge clk) disable iff (rst)
    (ph_pri && ph_sec && !force_take && opcode[CM:COND_LSB] == 2'b11) |-> (take_n == !cf));
  // R6: closed gate keeps the output steady
  a_r6_closed_steady: assert property (@(posedge clk) disable iff (rst)
    (!(ph_pri && ph_sec) && !$past(gate_open)) |-> $stable(take_n));
  // R7: closing the gate preserves the last open value
  a_r7_hold_on_close: assert property (@(posedge clk) disable iff (rst)
    ($past(gate_open) && !gate_open) |-> (take_n == $past(take_n)));
  // R8: out of reset, not taken until the gate opens
  a_r8_reset_idle: assert property (@(posedge clk) disable iff (rst)
    ($past(rst) && !gate_open) |-> take_n);
  // R9: unconditional request wins while open
  a_r9_force: assert property (@(posedge clk) disable iff (rst)
    (ph_pri && ph_sec && force_take) |-> !take_n);

endmodule

// File: tb/branch_cond_eval_test.sv
module branch_cond_eval_test;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [7:0] opcode = 8'h00;
  logic       zf = 1'b0, cf = 1'b0, force_take = 1'b0;
  logic       ph_pri = 1'b0, ph_sec = 1'b0;
  logic       take_n;
  int         checks = 0;
  int         fails  = 0;
  logic [7:0] acc;

  always #2.5 clk = ~clk;

  branch_cond_eval uut (
    .clk(clk), .rst(rst), .opcode(opcode), .zf(zf), .cf(cf),
    .force_take(force_take), .ph_pri(ph_pri), .ph_sec(ph_sec), .take_n(take_n)
  );

  task automatic check(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: take_n=%b expected %b", req, act, exp);
    end
  endtask

  // Expected taken (1) from the requirement text, computed independently.
  function automatic logic want_taken(input logic [7:0] op, input logic z, input logic c,
                                      input logic f);
    logic [1:0] sel;
    sel = op[4:3];
    if (f) return 1'b1;
    if (sel == 2'b00) return !z;
    if (sel == 2'b01) return z;
    if (sel == 2'b10) return !c;
    return c;
  endfunction

  // Open gate for one cycle, check transparent value, close, check held value.
  task automatic eval_cycle(input string req, input logic [7:0] op, input logic z,
                            input logic c, input logic f);
    logic exp_n;
    exp_n = !want_taken(op, z, c, f);
    @(negedge clk);
    opcode = op; zf = z; cf = c; force_take = f;
    ph_pri = 1'b1; ph_sec = 1'b1;
    #1 check(req, take_n, exp_n);
    @(negedge clk);
    ph_pri = 1'b0; ph_sec = 1'b0;
    #1 check({req, "/R7 hold"}, take_n, exp_n);
  endtask

  task automatic t_reset;
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 1'b0;
    #1 check("R8 after reset", take_n, 1'b1);
    @(negedge clk); opcode = 8'hC8; zf = 1'b1;
    #1 check("R8 idle before first gate", take_n, 1'b1);
  endtask

  task automatic t_conditions;
    for (int s = 0; s < 4; s++) begin
      for (int fl = 0; fl < 2; fl++) begin
        logic [7:0] op;
        op = 8'hC0 | 8'(s << 3);
        case (s)
          0: eval_cycle("R1 NZ", op, fl[0], 1'b0, 1'b0);
          1: eval_cycle("R2 Z",  op, fl[0], 1'b1, 1'b0);
          2: eval_cycle("R3 NC", op, 1'b0, fl[0], 1'b0);
          default: eval_cycle("R4 C", op, 1'b1, fl[0], 1'b0);
        endcase
      end
    end
  endtask

  task automatic t_other_bits;
    eval_cycle("R5 bits ignored", 8'h08, 1'b1, 1'b0, 1'b0);
    eval_cycle("R5 bits ignored", 8'hF7 & 8'hE7 | 8'h08, 1'b0, 1'b1, 1'b0);
    eval_cycle("R5 bits ignored", 8'h3F, 1'b1, 1'b0, 1'b0);
    eval_cycle("R5 bits ignored", 8'h27, 1'b0, 1'b1, 1'b0);
  endtask

  task automatic t_closed_gate;
    eval_cycle("R6 setup", 8'hC8, 1'b0, 1'b0, 1'b0); // held not taken
    @(negedge clk); zf = 1'b1; force_take = 1'b1;
    #1 check("R6 flags while closed", take_n, 1'b1);
    @(negedge clk); ph_pri = 1'b1;
    #1 check("R6 primary phase only", take_n, 1'b1);
    @(negedge clk); ph_pri = 1'b0; ph_sec = 1'b1;
    #1 check("R6 secondary phase only", take_n, 1'b1);
    @(negedge clk); ph_sec = 1'b0; force_take = 1'b0;
    eval_cycle("R6 setup taken", 8'hC8, 1'b1, 1'b0, 1'b0);
    @(negedge clk); zf = 1'b0; opcode = 8'hD8;
    #1 check("R6 closed keeps taken", take_n, 1'b0);
  endtask

  task automatic t_force;
    eval_cycle("R9 force NZ", 8'hC0, 1'b1, 1'b0, 1'b1);
    eval_cycle("R9 force C",  8'hD8, 1'b0, 1'b0, 1'b1);
  endtask

  task automatic t_sequence;
    acc = 8'h00;
    acc = acc + 8'd1; zf = (acc == 8'h00);
    eval_cycle("R10 ret z", 8'hC8, zf, cf, 1'b0);
    acc = acc - 8'd1; zf = (acc == 8'h00);
    eval_cycle("R10 ret nz", 8'hC0, zf, cf, 1'b0);
    cf = 1'b1;
    eval_cycle("R10 ret nc", 8'hD0, zf, cf, 1'b0);
    cf = !cf;
    eval_cycle("R10 ret c", 8'hD8, zf, cf, 1'b0);
  endtask

  initial begin
    t_reset();
    t_conditions();
    t_other_bits();
    t_closed_gate();
    t_force();
    t_sequence();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #100000;
    checks++; fails++;
    $display("FAIL watchdog: take_n=%b expected completion", take_n);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule